// File: doc/BRIEF.md
# Camera Serial Frame-Sequence Checker

The block watches the decoded packet events of a camera serial receiver and checks that each virtual channel follows the expected frame protocol. For every channel it keeps an in-frame flag, a count of accepted line packets, and a flag that records any line whose length differs from the configured horizontal resolution. From these it derives per-channel events: frame start seen, frame end seen, early start, early end, lost start, lost end, truncated frame and frame-size mismatch.

The packet's virtual channel picks the channel that it updates. Besides the per-channel events, the block records five global conditions. Three come from error flags driven by the packet decoder: unknown ID, checksum and header-code. The other two are found by decoding the data type: a filler type (null or blanking) and an unsupported colour type (RGB444 or RGB555).

All event bits gather into a sticky source vector. Software clears bits in that vector by writing ones. A mask vector selects which bits drive the single interrupt line.

Layout of the source vector, for NCH channels:
- bit 0 unknown ID, bit 1 checksum error, bit 2 header-code error, bit 3 filler type, bit 4 unsupported type;
- bits 7:5 always zero;
- from bit 8, eight NCH-bit fields with the channel index as the low-order offset: start seen, end seen, early start, early end, lost start, lost end, truncated, size error.

Field k for channel c therefore sits at bit 8 + k*NCH + c. With NCH = 4 the vector is 40 bits wide.

Top module: `csi_frame_seq_checker`

## Requirements
- R1: After reset the whole source vector reads zero and the interrupt line is low.
- R2: A valid start packet (kind 0) sets start-seen for the channel named by its virtual channel, and a valid end packet (kind 1) sets end-seen. Channel c lands at offset c within each field.
- R3: A start packet on a channel that is still in-frame sets lost-end for that channel. The start then restarts the frame with a line count of zero and a clean length record.
- R4: A start packet on an in-frame channel that has received at least one line, but fewer lines than the configured vertical resolution, also sets early-start.
- R5: An end packet on an out-of-frame channel sets lost-start, and so does an accepted line packet (kind 2) on an out-of-frame channel. Such a line is not counted.
- R6: An end packet on an in-frame channel that has received fewer lines than the vertical resolution sets truncated. If at least one line had arrived, it also sets early-end. Every end packet leaves the frame.
- R7: An end packet on an in-frame channel sets size-error when the line count differs from the vertical resolution, or when any counted line's length differed from the horizontal resolution.
- R8: A line (kind 2) or other (kind 3) packet sets bit 3 when its data type is 0x10 or 0x11, and bit 4 when its data type is 0x20 or 0x21. A line packet of those types is neither counted nor checked for lost-start.
- R9: The unknown-ID, checksum and header-code input flags set bits 0, 1 and 2 in the cycle they are high.
- R10: Source bits stay set until cleared. A clear strobe clears exactly the bits given as ones, and an event arriving in the same cycle wins over its clear.
- R11: The interrupt line is high exactly when some source bit is set whose mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet event strobe |
| pkt_kind | input | 2 | 0 start, 1 end, 2 line data, 3 other |
| pkt_dt | input | 6 | Packet data type |
| pkt_vc | input | VC_W | Virtual channel, selects the tracked channel |
| pkt_len | input | RES_W | Pixel count of a line packet |
| cfg_hres | input | RES_W | Configured horizontal resolution |
| cfg_vres | input | RES_W | Configured vertical resolution (lines) |
| err_id | input | 1 | Unknown-ID error flag |
| err_crc | input | 1 | Payload checksum error flag |
| err_ecc | input | 1 | Header-code error flag |
| int_mask | input | STAT_W | Interrupt enable per source bit, 1 = enabled |
| clr_en | input | 1 | Write-one-to-clear strobe |
| clr_bits | input | STAT_W | Bits to clear when clr_en is high |
| int_src | output | STAT_W | Sticky source vector |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default four channels and 16-bit resolution fields, and drives a horizontal resolution of 4 and a vertical resolution of 3. The short frames this gives place every line-count boundary within a few packets: no lines, a partial frame and an exact frame. Spreading the packets across all four virtual channels shows that each event lands at its own channel offset, and that state is kept separately for each channel.

// File: rtl/csi_fsc_pkg.sv
package csi_fsc_pkg;

  typedef enum logic [1:0] {
    PK_FS    = 2'd0,
    PK_FE    = 2'd1,
    PK_LINE  = 2'd2,
    PK_OTHER = 2'd3
  } pkt_kind_e;

  localparam logic [5:0] DT_NULL    = 6'h10;
  localparam logic [5:0] DT_BLANK   = 6'h11;
  localparam logic [5:0] DT_RGB444  = 6'h20;
  localparam logic [5:0] DT_RGB555  = 6'h21;

  localparam int GLOBAL_W = 8;
  localparam int CH_EV_N  = 8;

  // field k of the per-channel event record maps to source field k
  typedef struct packed {
    logic size_err;
    logic trunc;
    logic lost_fe;
    logic lost_fs;
    logic early_fe;
    logic early_fs;
    logic fe_seen;
    logic fs_seen;
  } chan_ev_t;

endpackage

// File: rtl/fsc_dt_classify.sv
module fsc_dt_classify
  import csi_fsc_pkg::*;
(
  input  logic      pkt_valid,
  input  pkt_kind_e pkt_kind,
  input  logic [5:0] pkt_dt,
  output logic      dt_filler,
  output logic      dt_unsup,
  output logic      line_ok
);

  logic payload_kind;
  logic is_filler;
  logic is_unsup;

  always_comb begin
    payload_kind = (pkt_kind == PK_LINE) || (pkt_kind == PK_OTHER);
    is_filler    = (pkt_dt == DT_NULL) || (pkt_dt == DT_BLANK);
    is_unsup     = (pkt_dt == DT_RGB444) || (pkt_dt == DT_RGB555);
    dt_filler    = pkt_valid && payload_kind && is_filler;
    dt_unsup     = pkt_valid && payload_kind && is_unsup;
    line_ok      = pkt_valid && (pkt_kind == PK_LINE) && !is_filler && !is_unsup;
  end

endmodule

// File: rtl/fsc_chan_tracker.sv
module fsc_chan_tracker
  import csi_fsc_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  pkt_kind_e        pkt_kind,
  input  logic             line_ok,
  input  logic [RES_W-1:0] pkt_len,
  input  logic [RES_W-1:0] cfg_hres,
  input  logic [RES_W-1:0] cfg_vres,
  output chan_ev_t         ev
);

  logic             in_frame_q, in_frame_d;
  logic [RES_W-1:0] lines_q, lines_d;
  logic             bad_q, bad_d;
  logic             fs_hit, fe_hit, line_hit, upd;
  logic             partial, short_frame;

  always_comb begin
    fs_hit      = sel && (pkt_kind == PK_FS);
    fe_hit      = sel && (pkt_kind == PK_FE);
    line_hit    = sel && line_ok;
    upd         = fs_hit || fe_hit || line_hit;
    short_frame = lines_q < cfg_vres;
    partial     = (lines_q != '0) && short_frame;

    in_frame_d = in_frame_q;
    lines_d    = lines_q;
    bad_d      = bad_q;
    ev         = '0;

    if (fs_hit) begin
      ev.fs_seen  = 1'b1;
      ev.lost_fe  = in_frame_q;
      ev.early_fs = in_frame_q && partial;
      in_frame_d  = 1'b1;
      lines_d     = '0;
      bad_d       = 1'b0;
    end else if (fe_hit) begin
      ev.fe_seen  = 1'b1;
      ev.lost_fs  = !in_frame_q;
      ev.trunc    = in_frame_q && short_frame;
      ev.early_fe = in_frame_q && partial;
      ev.size_err = in_frame_q && ((lines_q != cfg_vres) || bad_q);
      in_frame_d  = 1'b0;
    end else if (line_hit) begin
      if (!in_frame_q) begin
        ev.lost_fs = 1'b1;
      end else begin
        if (lines_q != '1) lines_d = lines_q + 1'b1;
        if (pkt_len != cfg_hres) bad_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      lines_q    <= '0;
      bad_q      <= 1'b0;
    end else if (upd) begin
      in_frame_q <= in_frame_d;
      lines_q    <= lines_d;
      bad_q      <= bad_d;
    end
  end

  // R3: a start always opens (or reopens) the frame
  a_r3_fs_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fs_hit |=> in_frame_q);

  // R6: every end leaves the frame
  a_r6_fe_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fe_hit |=> !in_frame_q);

  // R6: an early end is always also a truncated frame
  a_r6_early_implies_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    ev.early_fe |-> ev.trunc);

  // R5: an accepted in-frame line advances the count by one
  a_r5_line_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hit && in_frame_q && (lines_q != '1)) |=> (lines_q == $past(lines_q) + 1'b1));

endmodule

// File: rtl/fsc_event_reg.sv
module fsc_event_reg #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_in,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] mask,
  output logic [W-1:0] stat,
  output logic         irq
);

  logic [W-1:0] stat_q, stat_d, clr_eff;
  logic         upd;

  always_comb begin
    clr_eff = clr_en ? clr_bits : '0;
    upd     = clr_en || (|ev_in);
    stat_d  = (stat_q & ~clr_eff) | ev_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd) begin
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & mask);

  // R10: a set bit only drops when its clear bit was given
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_eff)) & ~stat_q) == '0));

  // R10: an event bit is set next cycle even under a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_in) |=> ((stat_q & $past(ev_in)) == $past(ev_in)));

  // R11: with a steady mask the line only rises after a new event
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $stable(mask)) |-> $past(|ev_in));

endmodule

// File: rtl/csi_frame_seq_checker.sv
module csi_frame_seq_checker
  import csi_fsc_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int RES_W  = 16,
  localparam int VC_W   = $clog2(NCH),
  localparam int STAT_W = GLOBAL_W + CH_EV_N * NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [1:0]        pkt_kind,
  input  logic [5:0]        pkt_dt,
  input  logic [VC_W-1:0]   pkt_vc,
  input  logic [RES_W-1:0]  pkt_len,
  input  logic [RES_W-1:0]  cfg_hres,
  input  logic [RES_W-1:0]  cfg_vres,
  input  logic              err_id,
  input  logic              err_crc,
  input  logic              err_ecc,
  input  logic [STAT_W-1:0] int_mask,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_bits,
  output logic [STAT_W-1:0] int_src,
  output logic              irq
);

  pkt_kind_e   kind;
  logic        dt_filler, dt_unsup, line_ok;
  chan_ev_t    ch_ev [NCH];
  logic [STAT_W-1:0] ev_vec;

  assign kind = pkt_kind_e'(pkt_kind);

  fsc_dt_classify u_dt (
    .pkt_valid (pkt_valid),
    .pkt_kind  (kind),
    .pkt_dt    (pkt_dt),
    .dt_filler (dt_filler),
    .dt_unsup  (dt_unsup),
    .line_ok   (line_ok)
  );

  assign ev_vec[0] = err_id;
  assign ev_vec[1] = err_crc;
  assign ev_vec[2] = err_ecc;
  assign ev_vec[3] = dt_filler;
  assign ev_vec[4] = dt_unsup;
  assign ev_vec[GLOBAL_W-1:5] = '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = pkt_valid && (pkt_vc == VC_W'(c));

    fsc_chan_tracker #(.RES_W(RES_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .pkt_kind (kind),
      .line_ok  (line_ok),
      .pkt_len  (pkt_len),
      .cfg_hres (cfg_hres),
      .cfg_vres (cfg_vres),
      .ev       (ch_ev[c])
    );

    for (genvar k = 0; k < CH_EV_N; k++) begin : g_fld
      assign ev_vec[GLOBAL_W + k*NCH + c] = ch_ev[c][k];
    end
  end

  fsc_event_reg #(.W(STAT_W)) u_evr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_in    (ev_vec),
    .clr_en   (clr_en),
    .clr_bits (clr_bits),
    .mask     (int_mask),
    .stat     (int_src),
    .irq      (irq)
  );

  // R2: at most one channel is touched by a packet
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_vec[GLOBAL_W +: NCH]));

endmodule

// File: tb/test_csi_frame_seq_checker.sv
`timescale 1ns/1ps
module test_csi_frame_seq_checker;

  localparam int NCH = 4;
  localparam int RES_W = 16;
  localparam int SW = 8 + 8*NCH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic [1:0] pkt_kind = '0;
  logic [5:0] pkt_dt = '0;
  logic [1:0] pkt_vc = '0;
  logic [RES_W-1:0] pkt_len = '0;
  logic [RES_W-1:0] cfg_hres = 16'd4;
  logic [RES_W-1:0] cfg_vres = 16'd3;
  logic err_id = 0, err_crc = 0, err_ecc = 0;
  logic [SW-1:0] int_mask = '0;
  logic clr_en = 1'b0;
  logic [SW-1:0] clr_bits = '0;
  logic [SW-1:0] int_src;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  csi_frame_seq_checker #(.NCH(NCH), .RES_W(RES_W)) i_csi_frame_seq_checker (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_kind(pkt_kind),
    .pkt_dt(pkt_dt), .pkt_vc(pkt_vc), .pkt_len(pkt_len), .cfg_hres(cfg_hres),
    .cfg_vres(cfg_vres), .err_id(err_id), .err_crc(err_crc), .err_ecc(err_ecc),
    .int_mask(int_mask), .clr_en(clr_en), .clr_bits(clr_bits),
    .int_src(int_src), .irq(irq)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  logic [SW-1:0] m_stat;
  bit   m_inf [NCH];
  int   m_lines [NCH];
  bit   m_bad [NCH];

  function automatic int bp(int k, int c);
    return 8 + k*NCH + c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0;
      for (int i = 0; i < NCH; i++) begin
        m_inf[i] = 0; m_lines[i] = 0; m_bad[i] = 0;
      end
    end else begin
      logic [SW-1:0] ev;
      ev = '0;
      ev[0] = err_id; ev[1] = err_crc; ev[2] = err_ecc;
      if (pkt_valid) begin
        int c;
        bit ign, uns;
        c = int'(pkt_vc);
        ign = (pkt_dt == 6'h10) || (pkt_dt == 6'h11);
        uns = (pkt_dt == 6'h20) || (pkt_dt == 6'h21);
        if (pkt_kind >= 2) begin ev[3] = ign; ev[4] = uns; end
        case (pkt_kind)
          2'd0: begin
            ev[bp(0,c)] = 1;
            if (m_inf[c]) begin
              ev[bp(5,c)] = 1;
              if (m_lines[c] > 0 && m_lines[c] < int'(cfg_vres)) ev[bp(2,c)] = 1;
            end
            m_inf[c] = 1; m_lines[c] = 0; m_bad[c] = 0;
          end
          2'd1: begin
            ev[bp(1,c)] = 1;
            if (!m_inf[c]) ev[bp(4,c)] = 1;
            else begin
              if (m_lines[c] < int'(cfg_vres)) ev[bp(6,c)] = 1;
              if (m_lines[c] > 0 && m_lines[c] < int'(cfg_vres)) ev[bp(3,c)] = 1;
              if (m_lines[c] != int'(cfg_vres) || m_bad[c]) ev[bp(7,c)] = 1;
            end
            m_inf[c] = 0;
          end
          2'd2: begin
            if (!ign && !uns) begin
              if (!m_inf[c]) ev[bp(4,c)] = 1;
              else begin
                if (m_lines[c] < 65535) m_lines[c]++;
                if (pkt_len != cfg_hres) m_bad[c] = 1;
              end
            end
          end
          default: ;
        endcase
      end
      m_stat = (m_stat & ~(clr_en ? clr_bits : '0)) | ev;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int_src !== m_stat) begin
        errors++;
        $display("FAIL R10 model compare: int_src=%h expected=%h", int_src, m_stat);
      end
      checks++;
      if (irq !== |(m_stat & int_mask)) begin
        errors++;
        $display("FAIL R11 model compare: irq=%b expected=%b", irq, |(m_stat & int_mask));
      end
    end
  end

  task automatic chk(string req, logic [SW-1:0] got, logic [SW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic pkt(int kind, int vc, int dt, int len);
    @(negedge clk);
    pkt_valid = 1; pkt_kind = 2'(kind); pkt_vc = 2'(vc);
    pkt_dt = 6'(dt); pkt_len = RES_W'(len);
    @(negedge clk);
    pkt_valid = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_en = 1; clr_bits = '1;
    @(negedge clk);
    clr_en = 0; clr_bits = '0;
  endtask

  function automatic logic [SW-1:0] b(int k, int c);
    return SW'(1) << bp(k, c);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 src in reset", int_src, '0);
    chk("R1 irq in reset", {39'd0, irq}, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 src after reset", int_src, '0);

    // R2 clean frame on channel 1
    pkt(0, 1, 6'h00, 0);
    for (int i = 0; i < 3; i++) pkt(2, 1, 6'h2B, 4);
    pkt(1, 1, 6'h01, 0);
    chk("R2 clean frame ch1", int_src, b(0,1) | b(1,1));
    chk("R11 masked irq low", {39'd0, irq}, '0);
    clear_all();
    chk("R10 clear all", int_src, '0);

    // R3 R4 restart mid-frame on channel 0
    pkt(0, 0, 6'h00, 0);
    pkt(2, 0, 6'h2A, 4);
    pkt(0, 0, 6'h00, 0);
    chk("R3 R4 lost end and early start", int_src, b(0,0) | b(5,0) | b(2,0));
    clear_all();
    // R6 end right after restart: zero lines
    pkt(1, 0, 6'h01, 0);
    chk("R6 R7 truncated empty frame", int_src, b(1,0) | b(6,0) | b(7,0));
    clear_all();

    // R5 lost start by end and by line
    pkt(1, 2, 6'h01, 0);
    chk("R5 end out of frame", int_src, b(1,2) | b(4,2));
    pkt(2, 3, 6'h2B, 4);
    chk("R5 line out of frame", int_src, b(1,2) | b(4,2) | b(4,3));
    clear_all();

    // R7 wrong line length, full count
    pkt(0, 0, 6'h00, 0);
    pkt(2, 0, 6'h2B, 4);
    pkt(2, 0, 6'h2B, 5);
    pkt(2, 0, 6'h2B, 4);
    pkt(1, 0, 6'h01, 0);
    chk("R7 line length mismatch", int_src, b(0,0) | b(1,0) | b(7,0));
    clear_all();

    // R6 partial frame
    pkt(0, 3, 6'h00, 0);
    pkt(2, 3, 6'h2B, 4);
    pkt(2, 3, 6'h2B, 4);
    pkt(1, 3, 6'h01, 0);
    chk("R6 early end", int_src, b(0,3) | b(1,3) | b(3,3) | b(6,3) | b(7,3));
    clear_all();

    // R8 data type flags
    pkt(3, 0, 6'h10, 0);
    chk("R8 filler type", int_src, SW'(1) << 3);
    pkt(2, 1, 6'h21, 4);
    chk("R8 unsupported line not lost start", int_src, (SW'(1) << 3) | (SW'(1) << 4));
    pkt(0, 2, 6'h00, 0);
    pkt(2, 2, 6'h11, 4);
    for (int i = 0; i < 3; i++) pkt(2, 2, 6'h2B, 4);
    pkt(1, 2, 6'h01, 0);
    chk("R8 filler line not counted", int_src,
        (SW'(1) << 3) | (SW'(1) << 4) | b(0,2) | b(1,2));
    clear_all();

    // R9 error flags
    @(negedge clk); err_id = 1; err_crc = 1; err_ecc = 1;
    @(negedge clk); err_id = 0; err_crc = 0; err_ecc = 0;
    chk("R9 error flags", int_src, SW'(7));

    // R10 set wins over clear, partial clear
    @(negedge clk); err_id = 1; clr_en = 1; clr_bits = SW'(3);
    @(negedge clk); err_id = 0; clr_en = 0; clr_bits = '0;
    chk("R10 set wins, bit1 cleared", int_src, SW'(5));

    // R11 mask
    int_mask = SW'(2);
    @(negedge clk);
    chk("R11 irq masked off", {39'd0, irq}, '0);
    int_mask = SW'(4);
    @(negedge clk);
    chk("R11 irq enabled", {39'd0, irq}, SW'(1));
    int_mask = '0;
    clear_all();
    chk("R10 final clear", int_src, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule